// File: doc/BRIEF.md
# Interleaved Dual-Bank Video Memory Bridge

This block lets a client see video memory as one linear byte window in which each 8-byte unit is split across two 32-bit memory banks. The low word of each 8-byte unit sits in a low bank and the high word sits in a high bank, so sequential 32-bit words alternate between the two halves of physical memory. A command gives a start address, a byte length and a direction. The bridge then walks the transfer one 32-bit word per cycle. It uses byte enables for a partial first word and a partial last word, so it never has to read, modify and write back.

The data stream is lane-aligned: byte lane k of a stream beat is byte lane k of the memory word it meets. For writes, the bridge takes one beat from `s_wdata` in every cycle where it raises `s_wtake`, and `s_lanes` names the lanes used. For reads, the memory returns data one cycle after the request, and the bridge forwards it on `s_rdata` with `s_rvalid` and `s_lanes`.

The controller has four states. ST_IDLE accepts a command. ST_MOVE issues one word per cycle. ST_DRAIN waits for the last read word to return. ST_DONE raises `done` for one cycle. The transitions are:
- accept: ST_IDLE to ST_MOVE, for a non-zero effective length.
- empty: ST_IDLE to ST_DONE, for a zero effective length.
- step: ST_MOVE stays in ST_MOVE while bytes remain.
- last_wr: ST_MOVE to ST_DONE after the final write word.
- last_rd: ST_MOVE to ST_DRAIN after the final read word.
- drained: ST_DRAIN to ST_DONE.
- release: ST_DONE to ST_IDLE.

Top module: `vbr_bridge`

## Requirements
- R1: Only the low AW bits of `cmd_addr` are used; the upper bits have no effect on the transfer.
- R2: If start plus length would pass the top of the 2^AW-byte window, the effective length is cut to end exactly at the top. The address never wraps.
- R3: The window byte address a maps to the memory word address {a[2], a[AW-1:3]}, so the high bank starts half a window (2^(AW-3) words) above the low bank. Memory byte lane = a[1:0], with lane k on data bits [8k+7:8k].
- R4: Words requested back to back within one transfer alternate between the banks. The most significant bit of `mem_addr` toggles on every request.
- R5: The first word enables lanes a[1:0] upward. It covers min(4 - a[1:0], length) bytes.
- R6: Every later word starts at lane 0. A full word enables all four lanes (`mem_be` = 4'b1111). A final partial word enables only the lowest (remaining) lanes.
- R7: Every request enables at least one lane. The enabled lanes of a transfer cover exactly the effective length and touch no other byte.
- R8: Write direction (`cmd_rd` = 0): each request has `mem_we` = 1 and `s_wtake` = 1. The stream word goes to memory in place, and `s_lanes` equals `mem_be`.
- R9: Read direction (`cmd_rd` = 1): memory data appears on `s_rdata` with `s_rvalid` = 1 one cycle after each request, and `s_lanes` gives that request's lanes.
- R10: `done` is high for exactly one cycle. It comes one cycle after the last byte moves: after the last write request, or after the last read word is returned. `cmd_ready` is high in the following cycle.
- R11: `cmd_ready` is low from acceptance until the bridge returns to idle. A command presented while busy is ignored.
- R12: A zero effective length makes no memory request, and `done` rises in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Bridge idle and accepting |
| cmd_addr | input | CMD_AW | Start byte address in the window |
| cmd_len | input | AW+1 | Byte length |
| cmd_rd | input | 1 | 1 = memory to stream, 0 = stream to memory |
| s_wdata | input | 32 | Lane-aligned write stream word |
| s_wtake | output | 1 | Write stream word consumed this cycle |
| s_rdata | output | 32 | Lane-aligned read stream word |
| s_rvalid | output | 1 | Read stream word valid |
| s_lanes | output | 4 | Valid lanes of the current stream beat |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW-2 | Physical word address, MSB is bank |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| done | output | 1 | Transfer complete pulse |

## Verification
The bench builds the bridge with AW = 10, which gives a 1 KiB window over 256 physical words. With that size a random start address lands near the window top often, so truncation (R2) is exercised by both random and directed transfers. A full physical memory image can also be compared after every write transfer, which exposes any stray lane or bank error. Upper address bits are randomized to show that they are ignored.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MOVE,
        ST_DRAIN,
        ST_DONE
    } vbr_state_e;
endpackage

// File: rtl/vbr_trunc.sv
module vbr_trunc #(
    parameter int AW = 23
) (
    input  logic [AW-1:0] start,
    input  logic [AW:0]   len,
    output logic [AW:0]   eff
);
    localparam logic [AW:0] WIN_TOP = {1'b1, {AW{1'b0}}};

    logic [AW:0] room;

    // Bytes left between the start address and the window top.
    assign room = WIN_TOP - {1'b0, start};
    assign eff  = (len > room) ? room : len;
endmodule

// File: rtl/vbr_lane_calc.sv
module vbr_lane_calc
    import vbr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [1:0]       off,
    input  logic [CNT_W-1:0] remain,
    output logic [2:0]       nbytes,
    output logic [LANES-1:0] be
);
    logic [2:0] avail;
    logic [3:0] hi;

    // Bytes up to the next word boundary, capped by what is left.
    assign avail  = 3'd4 - {1'b0, off};
    assign nbytes = (remain < CNT_W'(avail)) ? remain[2:0] : avail;
    assign hi     = {2'b00, off} + {1'b0, nbytes};

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign be[k] = (4'(k) >= {2'b00, off}) && (4'(k) < hi);
        end
    endgenerate
endmodule

// File: rtl/vbr_addr_map.sv
module vbr_addr_map #(
    parameter int AW = 23
) (
    input  logic [AW-1:0] vaddr,
    output logic [AW-3:0] paddr
);
    // Bit 2 picks the bank; the 8-byte unit index is the word within the bank.
    assign paddr = {vaddr[2], vaddr[AW-1:3]};
endmodule

// File: rtl/vbr_bridge.sv
module vbr_bridge
    import vbr_pkg::*;
#(
    parameter int AW     = 23,
    parameter int CMD_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [AW:0]       cmd_len,
    input  logic              cmd_rd,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_wtake,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_rvalid,
    output logic [LANES-1:0]  s_lanes,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-3:0]     mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done
);
    localparam int LEN_W   = AW + 1;
    localparam int WORD_AW = AW - 2;

    vbr_state_e state, state_nx;

    logic [AW-1:0]    cur_a;
    logic [LEN_W-1:0] remain;
    logic             dir_rd;
    logic             rd_pend;
    logic [LANES-1:0] rd_lanes;

    logic [AW-1:0]    start_a;
    logic [LEN_W-1:0] eff_len;
    logic [2:0]       nbytes;
    logic [LANES-1:0] step_be;
    logic             accept;
    logic             last_step;
    logic             unused_hi;

    assign start_a   = cmd_addr[AW-1:0];
    assign unused_hi = ^cmd_addr[CMD_AW-1:AW];

    vbr_trunc #(.AW(AW)) u_trunc (
        .start (start_a),
        .len   (cmd_len),
        .eff   (eff_len)
    );

    vbr_lane_calc #(.CNT_W(LEN_W)) u_lane (
        .off    (cur_a[1:0]),
        .remain (remain),
        .nbytes (nbytes),
        .be     (step_be)
    );

    vbr_addr_map #(.AW(AW)) u_map (
        .vaddr (cur_a),
        .paddr (mem_addr)
    );

    assign accept    = cmd_valid && (state == ST_IDLE);
    assign last_step = (remain == LEN_W'(nbytes));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = (eff_len == '0) ? ST_DONE : ST_MOVE;
            end
            ST_MOVE: begin
                if (last_step) state_nx = dir_rd ? ST_DRAIN : ST_DONE;
            end
            ST_DRAIN: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Transfer datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_a    <= '0;
            remain   <= '0;
            dir_rd   <= 1'b0;
            rd_pend  <= 1'b0;
            rd_lanes <= '0;
        end else begin
            rd_pend  <= (state == ST_MOVE) && dir_rd;
            rd_lanes <= step_be;
            if (accept) begin
                cur_a  <= start_a;
                remain <= eff_len;
                dir_rd <= cmd_rd;
            end else if (state == ST_MOVE) begin
                cur_a  <= cur_a + AW'(nbytes);
                remain <= remain - LEN_W'(nbytes);
            end
        end
    end

    // Outputs
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        mem_req   = (state == ST_MOVE);
        mem_we    = (state == ST_MOVE) && !dir_rd;
        mem_be    = (state == ST_MOVE) ? step_be : '0;
        mem_wdata = s_wdata;
        s_wtake   = (state == ST_MOVE) && !dir_rd;
        s_rvalid  = rd_pend;
        s_rdata   = mem_rdata;
        s_lanes   = rd_pend ? rd_lanes : (s_wtake ? step_be : '0);
        done      = (state == ST_DONE);
    end

    // R11
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cmd_ready);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    // R4
    bank_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr[WORD_AW-1] != $past(mem_addr[WORD_AW-1])));

    // R7
    lanes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be != '0));

    // R6
    later_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> mem_be[0]);

    // R9
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> $past(mem_req && !mem_we));
endmodule

// File: tb/tb_vbr_bridge.sv
module tb_vbr_bridge;
    localparam int AW    = 10;
    localparam int WIN   = 1 << AW;
    localparam int WORDS = WIN / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [AW:0] cmd_len = '0;
    logic        cmd_rd = 1'b0;
    logic [31:0] s_wdata = '0;
    logic        s_wtake;
    logic [31:0] s_rdata;
    logic        s_rvalid;
    logic [3:0]  s_lanes;
    logic        mem_req;
    logic        mem_we;
    logic [AW-3:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        done;

    logic [31:0] mem [WORDS];
    logic [7:0]  img [WIN];
    int nvec = 0;
    int nbad = 0;

    always #5 clk = ~clk;

    vbr_bridge #(.AW(AW), .CMD_AW(32)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_rd(cmd_rd),
        .s_wdata(s_wdata), .s_wtake(s_wtake), .s_rdata(s_rdata),
        .s_rvalid(s_rvalid), .s_lanes(s_lanes), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
    );

    // Memory model: byte-enabled writes, read data one cycle later
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (mem_req && mem_we) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
        end
        mem_rdata <= mem[mem_addr];
    end

    function automatic int pword(input int a);
        return ((a >> 2) & 1) * (WORDS / 2) + ((a >> 3) & (WORDS / 2 - 1));
    endfunction

    function automatic logic [3:0] lanes_of(input int off, input int n);
        return 4'(((1 << n) - 1) << off);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic image_chk(input string tg);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < WIN; a++) begin
            if (mem[pword(a)][8*(a & 3) +: 8] !== img[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        chk(bad == 0, {tg, " R7 R3 memory image byte mismatch count"}, 32'(bad), 32'd0);
    endtask

    task automatic xfer(input logic [31:0] addr, input int len, input bit rd, input bit jam, input string tg);
        int a, eff, p, rem, n, k;
        int pp, pn;
        logic [3:0] pl, ln;
        logic [31:0] wd, expw, msk;
        a   = int'(addr & (WIN - 1));
        eff = (len > WIN - a) ? WIN - a : len;
        @(negedge clk);
        chk(cmd_ready, {tg, " R11 ready when idle"}, 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b1; cmd_addr = addr; cmd_len = (AW+1)'(len); cmd_rd = rd;
        @(negedge clk);
        if (jam) begin
            cmd_addr = ~addr; cmd_len = 11'd7; cmd_rd = ~rd;
            chk(!cmd_ready, {tg, " R11 refuse while busy"}, 32'(cmd_ready), 32'd0);
        end else begin
            cmd_valid = 1'b0;
        end
        p = a; rem = eff; k = 0; pp = 0; pn = 0; pl = '0;
        if (eff == 0)
            chk(!mem_req, {tg, " R12 no request for empty transfer"}, 32'(mem_req), 32'd0);
        while (rem > 0) begin
            n  = (4 - (p & 3) < rem) ? 4 - (p & 3) : rem;
            ln = lanes_of(p & 3, n);
            if (!rd) begin
                wd = $urandom;
                for (int i = 0; i < n; i++) img[p + i] = wd[8*((p + i) & 3) +: 8];
                s_wdata = wd;
                chk(mem_req && mem_we && s_wtake && (s_lanes == ln),
                    {tg, " R8 write beat take/lanes"}, {s_wtake, mem_we, 26'd0, s_lanes}, {2'b11, 26'd0, ln});
            end else begin
                chk(mem_req && !mem_we, {tg, " R9 read request"}, 32'(mem_we), 32'd0);
                if (k > 0) begin
                    msk = '0; expw = '0;
                    for (int i = 0; i < pn; i++) begin
                        msk[8*((pp + i) & 3) +: 8]  = 8'hFF;
                        expw[8*((pp + i) & 3) +: 8] = img[pp + i];
                    end
                    chk(s_rvalid && (s_lanes == pl) && ((s_rdata & msk) == expw),
                        {tg, " R9 read data"}, s_rdata & msk, expw);
                end
            end
            chk(mem_be == ln, {tg, (k == 0) ? " R5 head lanes" : " R6 later lanes"}, 32'(mem_be), 32'(ln));
            chk(mem_addr == (AW-2)'(pword(p)), {tg, " R3 word address"}, 32'(mem_addr), 32'(pword(p)));
            pp = p; pn = n; pl = ln;
            p += n; rem -= n; k++;
            @(negedge clk);
        end
        if (rd && eff > 0) begin
            msk = '0; expw = '0;
            for (int i = 0; i < pn; i++) begin
                msk[8*((pp + i) & 3) +: 8]  = 8'hFF;
                expw[8*((pp + i) & 3) +: 8] = img[pp + i];
            end
            chk(s_rvalid && (s_lanes == pl) && ((s_rdata & msk) == expw) && !done,
                {tg, " R9 last read data"}, s_rdata & msk, expw);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(done && !mem_req, {tg, " R10 R2 done after last byte"}, {31'd0, done}, 32'd1);
        @(negedge clk);
        chk(!done && cmd_ready && !mem_req, {tg, " R10 single pulse then idle"}, {30'd0, done, cmd_ready}, 32'd1);
        if (!rd) image_chk(tg);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd7411);
        for (int a = 0; a < WIN; a++) img[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !mem_req && !done && !s_rvalid, "R11 reset idle", {29'd0, cmd_ready, mem_req, done}, 32'd4);

        // Directed corners
        xfer(32'h0000_0000, 16, 1'b0, 1'b0, "aligned");
        xfer(32'h0000_0005, 2, 1'b0, 1'b0, "inside_word");
        xfer(32'hABCD_E403, 13, 1'b0, 1'b0, "R1 upper_bits");
        xfer(32'h0000_03FC, 50, 1'b0, 1'b0, "R2 top_trunc");
        xfer(32'h0000_03FE, 9, 1'b0, 1'b0, "R2 top_trunc_short");
        xfer(32'h0000_0100, 0, 1'b0, 1'b0, "R12 zero_len");
        xfer(32'h0000_0046, 11, 1'b0, 1'b1, "R11 jam");
        xfer(32'h0000_0003, 20, 1'b1, 1'b0, "read_head");
        xfer(32'hFFFF_FC01, 30, 1'b1, 1'b0, "R1 read_upper");

        // Constrained random mix
        for (int t = 0; t < 60; t++) begin
            xfer($urandom, $urandom_range(0, 40), 1'(t % 3 == 2), 1'(t % 11 == 5), "random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule